// File: doc/BRIEF.md
# Chip-Enable Framed Serial Settings Receiver

This block receives control words over a three-wire serial link: a chip-enable line, a serial clock and a data line. The three lines are not synchronous to the system clock. Each one passes through a two-flop synchronizer, and the block detects its edges in the system clock domain. While chip-enable is high, each rising edge of the serial clock shifts one data bit into a frame register. The first eight bits carry a device address and the remaining twenty-four carry settings.

The block holds the settings in output registers that drive four switch enables, a left volume code, a right volume code, a tone-type select and two general-purpose port bits. None of these registers changes while a frame is arriving. When chip-enable falls, the received frame is judged as a whole. If it is good, every setting is replaced in the same system cycle and a one-cycle strobe is raised. If it is bad, nothing changes.

After reset the outputs stay in a muted state until the first good frame is committed.

Top module: `ser_ctl_rx`

## Requirements
- R1: After reset, and until the first accepted frame, `sw_en` is 0, `vol_l` and `vol_r` are all ones (the mute code), `tone_sel` is 0, `gp_out` is 0 and `upd_stb` is 0.
- R2: Bits are taken from `ctl_sdi` at rising edges of `ctl_sclk` while `ctl_ce` is high. The first eight bits are the address, least significant bit first. The next bits are data bits D0 to D23, in that order. The data fields are placed as follows:
  - D0–D3 go to `sw_en[0..3]`.
  - D4–D9 form `vol_l`, least significant bit first.
  - D10–D15 form `vol_r`, least significant bit first.
  - D16–D17 form `tone_sel`.
  - D18–D19 form `gp_out`.
  - D23 is not used.
- R3: Outputs change only when a frame is committed. The new values appear on the third rising system clock edge, counting from the first edge that samples `ctl_ce` low, which is the same edge that raises `upd_stb`. Outputs hold steady at every other time, including while a frame is being received.
- R4: A frame is committed only if exactly 32 serial clock rising edges were received while chip-enable was high. Frames of 31 or 33 bits are discarded.
- R5: A frame whose address is not equal to the `DEV_ADDR` parameter (default 8'hA5) is discarded.
- R6: A frame in which any of the reserved bits D20, D21 or D22 is 1 is discarded.
- R7: `upd_stb` is high for exactly one cycle for each committed frame. It stays low when a frame is discarded.
- R8: Serial clock edges are ignored while chip-enable is low. A serial clock rising edge that reaches the system clock domain in the same cycle as the chip-enable falling edge is not counted.
- R9: A rising edge of chip-enable clears any bits already received. A frame cut short and then followed by a complete frame still commits that complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_ce | input | 1 | Serial chip-enable; a frame is open while it is high |
| ctl_sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ctl_sdi | input | 1 | Serial data |
| sw_en | output | 4 | Input/output switch enables |
| vol_l | output | 6 | Left volume code (all ones = mute) |
| vol_r | output | 6 | Right volume code (all ones = mute) |
| tone_sel | output | 2 | Tone-type select |
| gp_out | output | 2 | General-purpose port bits |
| upd_stb | output | 1 | One-cycle strobe on each committed frame |

## Verification
Counting a bit and judging the frame can fall in the same system cycle. This happens when a serial clock rise and the chip-enable fall are synchronized together. The bench provokes it by sending 31 ordinary bits and then driving the 32nd clock rise and the chip-enable fall on the same system clock edge. That frame must be rejected, with no strobe and no change in any output. The behavioural model in the bench keeps its own three-deep history of the raw lines and reaches the same verdict by its own route. Every cycle is compared against that model, so a design that counted the coincident edge would commit the frame and show a mismatch.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int ADDR_W_D = 8;
  localparam int SW_N_D   = 4;
  localparam int VOL_W_D  = 6;
  localparam int TONE_W_D = 2;
  localparam int GP_N_D   = 2;
  localparam int TEST_N_D = 3;

  // Saturating bit counter step: stops at lim so an overlong frame stays overlong.
  function automatic int next_count(int cur, int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Decides whether a finished frame may be committed.
  function automatic logic frame_accept(int count, int frame_bits,
                                        logic addr_hit, logic test_clear);
    return (count == frame_bits) && addr_hit && test_clear;
  endfunction
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/ser_ctl_shift.sv
module ser_ctl_shift #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     ce_rise,
  input  logic                                     shift_en,
  input  logic                                     sdi,
  output logic [$clog2(ADDR_W+DATA_W+2)-1:0]       cnt,
  output logic [ADDR_W+DATA_W-2:0]                 frame
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int SR_W       = FRAME_BITS - 1;   // the final spare bit is counted, not stored
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      frame <= '0;
    end else if (ce_rise) begin
      cnt <= '0;
    end else if (shift_en) begin
      cnt <= CNT_W'(ser_ctl_pkg::next_count(int'(cnt), FRAME_BITS + 1));
      if (int'(cnt) < SR_W) frame <= {sdi, frame[SR_W-1:1]};
    end
  end
endmodule

// File: rtl/ser_ctl_commit.sv
module ser_ctl_commit #(
  parameter logic [7:0] DEV_ADDR = 8'hA5,
  parameter int ADDR_W = 8,
  parameter int SW_N   = 4,
  parameter int VOL_W  = 6,
  parameter int TONE_W = 2,
  parameter int GP_N   = 2,
  parameter int TEST_N = 3,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_fall,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [ADDR_W+DATA_W-2:0]   frame,
  output logic [SW_N-1:0]            sw_en,
  output logic [VOL_W-1:0]           vol_l,
  output logic [VOL_W-1:0]           vol_r,
  output logic [TONE_W-1:0]          tone_sel,
  output logic [GP_N-1:0]            gp_out,
  output logic                       upd_stb
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int SW_LO = ADDR_W;
  localparam int VL_LO = SW_LO + SW_N;
  localparam int VR_LO = VL_LO + VOL_W;
  localparam int TN_LO = VR_LO + VOL_W;
  localparam int GP_LO = TN_LO + TONE_W;
  localparam int TS_LO = GP_LO + GP_N;

  logic addr_hit, test_clear, accept;
  assign addr_hit   = (frame[ADDR_W-1:0] == DEV_ADDR[ADDR_W-1:0]);
  assign test_clear = (frame[TS_LO +: TEST_N] == '0);
  assign accept     = ce_fall &&
                      ser_ctl_pkg::frame_accept(int'(cnt), FRAME_BITS, addr_hit, test_clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en    <= '0;
      vol_l    <= '1;
      vol_r    <= '1;
      tone_sel <= '0;
      gp_out   <= '0;
      upd_stb  <= 1'b0;
    end else begin
      upd_stb <= accept;
      if (accept) begin
        sw_en    <= frame[SW_LO +: SW_N];
        vol_l    <= frame[VL_LO +: VOL_W];
        vol_r    <= frame[VR_LO +: VOL_W];
        tone_sel <= frame[TN_LO +: TONE_W];
        gp_out   <= frame[GP_LO +: GP_N];
      end
    end
  end
endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx #(
  parameter logic [7:0] DEV_ADDR = 8'hA5,
  parameter int ADDR_W = ser_ctl_pkg::ADDR_W_D,
  parameter int SW_N   = ser_ctl_pkg::SW_N_D,
  parameter int VOL_W  = ser_ctl_pkg::VOL_W_D,
  parameter int TONE_W = ser_ctl_pkg::TONE_W_D,
  parameter int GP_N   = ser_ctl_pkg::GP_N_D,
  parameter int TEST_N = ser_ctl_pkg::TEST_N_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_ce,
  input  logic              ctl_sclk,
  input  logic              ctl_sdi,
  output logic [SW_N-1:0]   sw_en,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output logic [TONE_W-1:0] tone_sel,
  output logic [GP_N-1:0]   gp_out,
  output logic              upd_stb
);
  localparam int DATA_W     = SW_N + 2*VOL_W + TONE_W + GP_N + TEST_N + 1;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int TS_LO      = ADDR_W + SW_N + 2*VOL_W + TONE_W + GP_N;
  localparam int OUT_W      = SW_N + 2*VOL_W + TONE_W + GP_N;

  logic [2:0] sync_q;
  logic       ce_lvl, sclk_lvl, sdi_lvl;
  logic       ce_prev, sclk_prev;
  logic       ce_rise, ce_fall, sclk_rise, shift_en;
  logic [CNT_W-1:0]        bit_cnt;
  logic [FRAME_BITS-2:0]   frame_sr;
  logic [TEST_N-1:0]       test_field;

  ser_ctl_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_sdi, ctl_sclk, ctl_ce}), .q(sync_q)
  );
  assign ce_lvl   = sync_q[0];
  assign sclk_lvl = sync_q[1];
  assign sdi_lvl  = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      ce_prev   <= ce_lvl;
      sclk_prev <= sclk_lvl;
    end
  end

  assign ce_rise   = ce_lvl & ~ce_prev;
  assign ce_fall   = ~ce_lvl & ce_prev;
  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign shift_en  = sclk_rise & ce_lvl;   // coincident CE fall leaves ce_lvl low

  ser_ctl_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .shift_en(shift_en),
    .sdi(sdi_lvl), .cnt(bit_cnt), .frame(frame_sr)
  );

  assign test_field = frame_sr[TS_LO +: TEST_N];

  ser_ctl_commit #(
    .DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .SW_N(SW_N), .VOL_W(VOL_W),
    .TONE_W(TONE_W), .GP_N(GP_N), .TEST_N(TEST_N), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_commit (
    .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .cnt(bit_cnt), .frame(frame_sr),
    .sw_en(sw_en), .vol_l(vol_l), .vol_r(vol_r), .tone_sel(tone_sel),
    .gp_out(gp_out), .upd_stb(upd_stb)
  );
endmodule

// File: rtl/ser_ctl_rx_chk.sv
module ser_ctl_rx_chk #(
  parameter int CNT_W      = 6,
  parameter int TEST_N     = 3,
  parameter int OUT_W      = 20,
  parameter int FRAME_BITS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_lvl,
  input logic              ce_fall,
  input logic              sclk_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [TEST_N-1:0] test_field,
  input logic [OUT_W-1:0]  outs,
  input logic              upd_stb
);
  assert_stb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(outs));

  assert_commit_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(ce_fall));

  assert_exact_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS)));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= FRAME_BITS + 1);

  assert_test_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> ($past(test_field) == '0));

  assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lvl && sclk_rise) |=> (bit_cnt == $past(bit_cnt) || bit_cnt == '0));
endmodule

bind ser_ctl_rx ser_ctl_rx_chk #(
  .CNT_W(CNT_W), .TEST_N(TEST_N), .OUT_W(OUT_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_lvl(ce_lvl), .ce_fall(ce_fall),
  .sclk_rise(sclk_rise), .bit_cnt(bit_cnt), .test_field(test_field),
  .outs({sw_en, vol_l, vol_r, tone_sel, gp_out}), .upd_stb(upd_stb)
);

// File: tb/ser_ctl_rx_test.sv
module ser_ctl_rx_test;
  localparam int HB = 4;
  localparam logic [7:0] ADDR = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_ce = 1'b0, ctl_sclk = 1'b0, ctl_sdi = 1'b0;
  logic [3:0] sw_en;
  logic [5:0] vol_l, vol_r;
  logic [1:0] tone_sel, gp_out;
  logic upd_stb;

  always #4 clk = ~clk;

  ser_ctl_rx uut (
    .clk(clk), .rst_n(rst_n), .ctl_ce(ctl_ce), .ctl_sclk(ctl_sclk), .ctl_sdi(ctl_sdi),
    .sw_en(sw_en), .vol_l(vol_l), .vol_r(vol_r), .tone_sel(tone_sel),
    .gp_out(gp_out), .upd_stb(upd_stb)
  );

  int compared = 0, mismatched = 0, strobes = 0, cyc = 0;
  logic model_on = 1'b1;

  // behavioural reference model
  bit q[$];
  int h1c, h2c, h3c, h1k, h2k, h3k, h1d, h2d, h3d;
  int e_sw, e_vl, e_vr, e_tn, e_gp, e_stb;

  function automatic int field(int lo, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v += int'(q[8 + lo + i]) << i;
    return v;
  endfunction

  function automatic bit good_frame();
    int a = 0;
    if (q.size() != 32) return 0;
    for (int i = 0; i < 8; i++) a += int'(q[i]) << i;
    if (a != int'(ADDR)) return 0;
    return field(20, 3) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1c = 0; h2c = 0; h3c = 0; h1k = 0; h2k = 0; h3k = 0; h1d = 0; h2d = 0; h3d = 0;
      q.delete();
      e_sw = 0; e_vl = 63; e_vr = 63; e_tn = 0; e_gp = 0; e_stb = 0;
    end else begin
      e_stb = 0;
      if (h2c == 1 && h3c == 0) q.delete();
      else if (h2k == 1 && h3k == 0 && h2c == 1) q.push_back(bit'(h2d));
      if (h2c == 0 && h3c == 1 && good_frame()) begin
        e_sw = field(0, 4); e_vl = field(4, 6); e_vr = field(10, 6);
        e_tn = field(16, 2); e_gp = field(18, 2); e_stb = 1;
      end
      h3c = h2c; h2c = h1c; h1c = int'(ctl_ce);
      h3k = h2k; h2k = h1k; h1k = int'(ctl_sclk);
      h3d = h2d; h2d = h1d; h1d = int'(ctl_sdi);
    end
  end

  task automatic check(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint pack_out();
    return {sw_en, vol_l, vol_r, tone_sel, gp_out, upd_stb};
  endfunction
  function automatic longint pack_exp();
    return {4'(e_sw), 6'(e_vl), 6'(e_vr), 2'(e_tn), 2'(e_gp), 1'(e_stb)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && model_on) check("R3 cycle compare", pack_out(), pack_exp());
    if (rst_n && upd_stb) strobes++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired expected=finish actual=hang");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic waitc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sends nbits of {data, addr}, LSB first; leaves CE high
  task automatic send_bits(logic [7:0] a, logic [23:0] d, int nbits);
    logic [39:0] f = {8'h00, d, a};
    ctl_ce = 1'b1; waitc(HB);
    for (int i = 0; i < nbits; i++) begin
      ctl_sdi = f[i % 40]; waitc(HB);
      ctl_sclk = 1'b1; waitc(HB);
      ctl_sclk = 1'b0;
    end
    waitc(HB);
  endtask

  task automatic close_frame();
    ctl_ce = 1'b0; waitc(8);
  endtask

  function automatic logic [23:0] mk(int sw, int vl, int vr, int tn, int gp, int tst);
    return {1'b0, 3'(tst), 2'(gp), 2'(tn), 6'(vr), 6'(vl), 4'(sw)};
  endfunction

  task automatic check_outs(string tag, int sw, int vl, int vr, int tn, int gp);
    check(tag, {sw_en, vol_l, vol_r, tone_sel, gp_out},
          {4'(sw), 6'(vl), 6'(vr), 2'(tn), 2'(gp)});
  endtask

  initial begin
    int s0;
    waitc(5);
    check_outs("R1 reset state", 0, 63, 63, 0, 0);
    check("R1 strobe low", upd_stb, 0);
    rst_n = 1'b1; waitc(3);

    // R2 / R7: a good frame
    s0 = strobes;
    send_bits(ADDR, mk(4'hA, 6'h15, 6'h2C, 2, 1, 0), 32);
    check_outs("R3 held during frame", 0, 63, 63, 0, 0);
    close_frame();
    check_outs("R2 fields frame A", 4'hA, 6'h15, 6'h2C, 2, 1);
    check("R7 one strobe", strobes - s0, 1);

    // R2: second pattern
    send_bits(ADDR, mk(4'h5, 6'h00, 6'h3E, 3, 2, 0), 32); close_frame();
    check_outs("R2 fields frame B", 4'h5, 6'h00, 6'h3E, 3, 2);

    // R5: wrong address
    s0 = strobes;
    send_bits(8'h5A, mk(4'hF, 1, 1, 1, 3, 0), 32); close_frame();
    check_outs("R5 bad address ignored", 4'h5, 6'h00, 6'h3E, 3, 2);
    check("R7 no strobe on discard", strobes - s0, 0);

    // R4: short and long frames
    send_bits(ADDR, mk(4'hF, 1, 1, 1, 3, 0), 31); close_frame();
    check_outs("R4 31 bits ignored", 4'h5, 6'h00, 6'h3E, 3, 2);
    send_bits(ADDR, mk(4'hF, 1, 1, 1, 3, 0), 33); close_frame();
    check_outs("R4 33 bits ignored", 4'h5, 6'h00, 6'h3E, 3, 2);

    // R6: each reserved bit
    for (int t = 0; t < 3; t++) begin
      send_bits(ADDR, mk(4'hF, 1, 1, 1, 3, 1 << t), 32); close_frame();
      check_outs("R6 test bit rejects", 4'h5, 6'h00, 6'h3E, 3, 2);
    end

    // R8: clock pulses while CE low are ignored
    for (int i = 0; i < 5; i++) begin
      ctl_sclk = 1'b1; waitc(HB); ctl_sclk = 1'b0; waitc(HB);
    end
    check_outs("R8 idle clocks no effect", 4'h5, 6'h00, 6'h3E, 3, 2);

    // R8: 32nd rise coincident with CE fall is not counted
    s0 = strobes;
    send_bits(ADDR, mk(4'h3, 7, 9, 1, 0, 0), 31);
    ctl_sdi = 1'b0; waitc(HB);
    ctl_sclk = 1'b1; ctl_ce = 1'b0; waitc(HB);
    ctl_sclk = 1'b0; waitc(8);
    check_outs("R8 coincident edge dropped", 4'h5, 6'h00, 6'h3E, 3, 2);
    check("R8 no strobe", strobes - s0, 0);

    // R9: aborted partial frame then a full frame
    send_bits(ADDR, mk(4'hF, 63, 63, 3, 3, 7), 13);
    ctl_ce = 1'b0; waitc(HB);
    send_bits(ADDR, mk(4'h6, 6'h21, 6'h12, 0, 3, 0), 32); close_frame();
    check_outs("R9 restart commits", 4'h6, 6'h21, 6'h12, 0, 3);

    // R3: exact commit cycle
    send_bits(ADDR, mk(4'h9, 6'h0F, 6'h30, 1, 0, 0), 32);
    ctl_ce = 1'b0;
    waitc(2);
    check_outs("R3 not yet at edge 2", 4'h6, 6'h21, 6'h12, 0, 3);
    waitc(1);
    check_outs("R3 new at edge 3", 4'h9, 6'h0F, 6'h30, 1, 0);
    check("R7 strobe at commit edge", upd_stb, 1);
    waitc(1);
    check("R7 strobe one cycle", upd_stb, 0);
    waitc(6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule